// File: doc/BRIEF.md
# Chained Transfer Controller

A single request-driven move engine. When a source raises an activation request and the enable bit for that source is set, the engine fetches a register set (descriptor) from memory. It reads one word from the source address and writes it to the destination address. It then writes the decremented transfer count back into the descriptor. A control byte in the descriptor decides what happens next: fetch the following descriptor and move again, stop quietly, clear the flag of the requesting source, or pass an interrupt to the CPU. When the count runs out, the engine also clears the enable bit of the source.

A descriptor is four 32-bit words at a 16-byte stride:
- word 0 holds the mode byte in bits 31:24, a free byte in bits 23:16 and the count in bits 15:0;
- word 1 is the source address;
- word 2 is the destination address;
- word 3 is not used.

The first descriptor of source `s` is at `INFO_BASE + s * 2**SLOT_SHIFT`. Each chained descriptor follows the previous one directly. The memory port is a single-master request/ready pair. A beat completes on a clock edge where `mem_req` and `mem_ready` are both high, and read data is taken in that same cycle.

States and transitions:
- IDLE goes to READ_INFO on an accepted activation.
- READ_INFO performs three beats (words 0, 1 and 2), then goes to READ_DATA.
- READ_DATA goes to WRITE_DATA.
- WRITE_DATA goes to WRITE_BACK.
- WRITE_BACK goes to DECIDE.
- DECIDE goes to READ_INFO (chain) or to IDLE (end).

Every state except IDLE and DECIDE advances only on a completed beat. DECIDE lasts exactly one cycle, and every event output pulses in that cycle.

Top module: `xfer_chain_ctrl`

## Requirements
- R1: An activation is accepted only in IDLE and only when the enable bit indexed by `act_src` is 1. Any other request causes no memory access and no event, including a request made while a transfer is in progress.
- R2: Each step makes these beats in order:
  - reads at P, P+4 and P+8;
  - a read at the source address;
  - a write of that data to the destination address;
  - a write at P of word 0 with bits 31:16 unchanged and bits 15:0 equal to the count minus 1, modulo 2^16.
  P is the descriptor address described above.
- R3: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R4: Mode bit 7 set and bit 5 clear means that the engine always chains to the descriptor at P+16. A chaining step clears no flag, clears no enable bit and raises no CPU interrupt.
- R5: Mode bits 7 and 5 both set means that the engine chains only when the updated count is 0. Otherwise it returns to IDLE with no event and no enable change.
- R6: Mode bit 7 clear, bit 6 clear and an updated count other than 0 give a one-cycle `src_clr` pulse carrying the source index, and no `cpu_irq`.
- R7: Mode bit 7 clear and bit 6 set give a one-cycle `cpu_irq` pulse carrying the source index, and no `src_clr`.
- R8: Mode bit 7 clear and an updated count of 0 clear the enable bit of the source and give `cpu_irq` without `src_clr`.
- R9: Mode bits 4:0 and word-0 bits 23:16 have no effect on behaviour, and the write-back returns bits 23:16 unchanged.
- R10: When a software write (`en_wr`) coincides with a hardware enable clear, the written value is applied, and the bit being cleared ends at 0.
- R11: A starting count of 0 becomes 0xFFFF, which is treated as not exhausted.
- R12: After reset, `en_q` is 0 and all outputs are low. `src_clr` and `cpu_irq` are never high together, and either one is high only in DECIDE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_req | input | 1 | Activation request |
| act_src | input | SW | Index of the requesting source |
| en_wr | input | 1 | Software write strobe for the enable register |
| en_wdata | input | NSRC | Value written into the enable register |
| en_q | output | NSRC | Per-source enable register |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Beat completes on this edge |
| src_clr | output | 1 | Pulse: clear the flag of the requesting source |
| src_clr_id | output | SW | Source index for `src_clr` |
| cpu_irq | output | 1 | Pulse: interrupt forwarded to the CPU |
| cpu_irq_id | output | SW | Source index for `cpu_irq` |

## Verification
The coincidence that matters is a software write to the enable register in the same DECIDE cycle in which an exhausted count clears the enable bit of a source. The bench watches for the `cpu_irq` pulse of a descriptor with count 1 and drives an all-ones `en_wr` in that very cycle. It then expects every bit set except the finishing source. A second coincidence is an activation presented while a chain is running. That request must leave no trace on the memory port, which the bench's transaction model rejects as an unexpected beat.

// File: rtl/xcc_pkg.sv
package xcc_pkg;

    localparam int WORD_W    = 32;
    localparam int CNT_W     = 16;
    localparam int SET_BYTES = 16;
    localparam int INFO_BEATS = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_INFO,
        ST_READ_DATA,
        ST_WRITE_DATA,
        ST_WRITE_BACK,
        ST_DECIDE
    } xcc_state_e;

    typedef struct packed {
        logic chain_en;
        logic irq_pass;
        logic chain_on_zero;
    } xcc_mode_t;

    function automatic xcc_mode_t decode_mode(input logic [7:0] mb);
        xcc_mode_t m;
        m.chain_en      = mb[7];
        m.irq_pass      = mb[6];
        m.chain_on_zero = mb[5];
        return m;
    endfunction

endpackage

// File: rtl/xcc_seq.sv
module xcc_seq
    import xcc_pkg::*;
#(
    parameter int            NSRC       = 8,
    parameter int            AW         = 32,
    parameter int            SLOT_SHIFT = 8,
    parameter logic [AW-1:0] INFO_BASE  = '0,
    localparam int           SW         = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_req,
    input  logic [SW-1:0]     act_src,
    input  logic [NSRC-1:0]   en_q,
    input  logic              do_chain,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              in_decide,
    output logic [SW-1:0]     cur_src,
    output logic [7:0]        mode_byte,
    output logic [CNT_W-1:0]  cnt_now
);

    xcc_state_e state_q, state_d;

    logic [1:0]        widx_q;
    logic [AW-1:0]     ptr_q;
    logic [AW-1:0]     sar_q;
    logic [AW-1:0]     dar_q;
    logic [WORD_W-1:0] w0_q;
    logic [WORD_W-1:0] data_q;
    logic [SW-1:0]     src_q;
    logic              start;
    logic              beat;
    logic [CNT_W-1:0]  cnt_dec;

    assign start   = (state_q == ST_IDLE) && act_req && en_q[act_src];
    assign beat    = mem_req && mem_ready;
    assign cnt_dec = w0_q[CNT_W-1:0] - CNT_W'(1);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = ST_READ_INFO;
            ST_READ_INFO:  if (beat && widx_q == 2'(INFO_BEATS - 1)) state_d = ST_READ_DATA;
            ST_READ_DATA:  if (beat) state_d = ST_WRITE_DATA;
            ST_WRITE_DATA: if (beat) state_d = ST_WRITE_BACK;
            ST_WRITE_BACK: if (beat) state_d = ST_DECIDE;
            ST_DECIDE:     state_d = do_chain ? ST_READ_INFO : ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            widx_q  <= '0;
            ptr_q   <= '0;
            sar_q   <= '0;
            dar_q   <= '0;
            w0_q    <= '0;
            data_q  <= '0;
            src_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    ptr_q  <= INFO_BASE + (AW'(act_src) << SLOT_SHIFT);
                    src_q  <= act_src;
                    widx_q <= '0;
                end
                ST_READ_INFO: if (beat) begin
                    unique case (widx_q)
                        2'd0:    w0_q  <= mem_rdata;
                        2'd1:    sar_q <= mem_rdata[AW-1:0];
                        default: dar_q <= mem_rdata[AW-1:0];
                    endcase
                    widx_q <= (widx_q == 2'(INFO_BEATS - 1)) ? 2'd0 : widx_q + 2'd1;
                end
                ST_READ_DATA:  if (beat) data_q <= mem_rdata;
                ST_WRITE_DATA: ;
                ST_WRITE_BACK: if (beat) w0_q[CNT_W-1:0] <= cnt_dec;
                ST_DECIDE: if (do_chain) begin
                    ptr_q  <= ptr_q + AW'(SET_BYTES);
                    widx_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ_INFO: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + AW'({widx_q, 2'b00});
            end
            ST_READ_DATA: begin
                mem_req  = 1'b1;
                mem_addr = sar_q;
            end
            ST_WRITE_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dar_q;
                mem_wdata = data_q;
            end
            ST_WRITE_BACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q;
                mem_wdata = {w0_q[WORD_W-1:CNT_W], cnt_dec};
            end
            ST_DECIDE: ;
            default: ;
        endcase
    end

    assign in_decide = (state_q == ST_DECIDE);
    assign cur_src   = src_q;
    assign mode_byte = w0_q[WORD_W-1:WORD_W-8];
    assign cnt_now   = w0_q[CNT_W-1:0];

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata)));

    // R1
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && $past(state_q == ST_IDLE)) |-> $past(act_req && en_q[act_src]));

    // R4
    chain_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_decide && do_chain) |=> (mem_req && !mem_we
                                     && mem_addr == $past(ptr_q) + AW'(SET_BYTES)));

endmodule

// File: rtl/xcc_decide.sv
module xcc_decide
    import xcc_pkg::*;
(
    input  logic             in_decide,
    input  logic [7:0]       mode_byte,
    input  logic [CNT_W-1:0] cnt_now,
    output logic             do_chain,
    output logic             src_clr,
    output logic             cpu_irq,
    output logic             en_clr
);

    xcc_mode_t mode;
    logic      cnt_zero;
    logic      finish;

    always_comb begin
        mode     = decode_mode(mode_byte);
        cnt_zero = (cnt_now == '0);
        finish   = in_decide && !mode.chain_en;
        do_chain = in_decide && mode.chain_en && (!mode.chain_on_zero || cnt_zero);
        en_clr   = finish && cnt_zero;
        cpu_irq  = finish && (mode.irq_pass || cnt_zero);
        src_clr  = finish && !mode.irq_pass && !cnt_zero;
    end

endmodule

// File: rtl/xcc_enable_reg.sv
module xcc_enable_reg #(
    parameter int  NSRC = 8,
    localparam int SW   = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_wdata,
    input  logic            en_clr,
    input  logic [SW-1:0]   clr_src,
    output logic [NSRC-1:0] en_q
);

    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] en_d;

    always_comb begin
        clr_mask = '0;
        if (en_clr) clr_mask[clr_src] = 1'b1;
        en_d = (en_wr ? en_wdata : en_q) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // R8 R10
    en_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> ((en_q & $past(clr_mask)) == '0));

    // R1
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_clr && !en_wr) |=> $stable(en_q));

endmodule

// File: rtl/xfer_chain_ctrl.sv
module xfer_chain_ctrl
    import xcc_pkg::*;
#(
    parameter int            NSRC       = 8,
    parameter int            AW         = 32,
    parameter int            SLOT_SHIFT = 8,
    parameter logic [AW-1:0] INFO_BASE  = '0,
    localparam int           SW         = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_req,
    input  logic [SW-1:0]     act_src,
    input  logic              en_wr,
    input  logic [NSRC-1:0]   en_wdata,
    output logic [NSRC-1:0]   en_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              src_clr,
    output logic [SW-1:0]     src_clr_id,
    output logic              cpu_irq,
    output logic [SW-1:0]     cpu_irq_id
);

    logic             in_decide;
    logic             do_chain;
    logic             en_clr;
    logic [SW-1:0]    cur_src;
    logic [7:0]       mode_byte;
    logic [CNT_W-1:0] cnt_now;

    xcc_seq #(
        .NSRC(NSRC), .AW(AW), .SLOT_SHIFT(SLOT_SHIFT), .INFO_BASE(INFO_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .act_req(act_req), .act_src(act_src), .en_q(en_q),
        .do_chain(do_chain),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .in_decide(in_decide), .cur_src(cur_src),
        .mode_byte(mode_byte), .cnt_now(cnt_now)
    );

    xcc_decide u_decide (
        .in_decide(in_decide), .mode_byte(mode_byte), .cnt_now(cnt_now),
        .do_chain(do_chain), .src_clr(src_clr), .cpu_irq(cpu_irq), .en_clr(en_clr)
    );

    xcc_enable_reg #(.NSRC(NSRC)) u_enable (
        .clk(clk), .rst_n(rst_n),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .en_clr(en_clr), .clr_src(cur_src), .en_q(en_q)
    );

    assign src_clr_id = cur_src;
    assign cpu_irq_id = cur_src;

    // R12
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_clr && cpu_irq));

    // R12
    event_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr || cpu_irq) |-> (in_decide && !mem_req));

    // R4
    chain_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_chain |-> (!src_clr && !cpu_irq && !en_clr));

endmodule

// File: tb/xfer_chain_ctrl_bench.sv
module xfer_chain_ctrl_bench;

    localparam int NSRC = 8;
    localparam int SW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            act_req = 1'b0;
    logic [SW-1:0]   act_src = '0;
    logic            en_wr = 1'b0;
    logic [NSRC-1:0] en_wdata = '0;
    logic [NSRC-1:0] en_q;
    logic            mem_req, mem_we;
    logic [31:0]     mem_addr, mem_wdata, mem_rdata;
    logic            mem_ready = 1'b0;
    logic            src_clr, cpu_irq;
    logic [SW-1:0]   src_clr_id, cpu_irq_id;

    always #5 clk = ~clk;

    xfer_chain_ctrl u_xfer_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_src(act_src),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_q(en_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .src_clr(src_clr), .src_clr_id(src_clr_id),
        .cpu_irq(cpu_irq), .cpu_irq_id(cpu_irq_id)
    );

    logic [31:0] mem [1024];
    logic [31:0] sh  [1024];
    logic [NSRC-1:0] men = '0;

    assign mem_rdata = mem[mem_addr[11:2]];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected transactions: kind 0 read, 1 write, 2 src_clr, 3 cpu_irq
    int          qk [$];
    logic [31:0] qa [$];
    logic [31:0] qd [$];
    string       qt [$];

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic pushx(input int k, input logic [31:0] a, input logic [31:0] d,
                         input string t);
        qk.push_back(k); qa.push_back(a); qd.push_back(d); qt.push_back(t);
    endtask

    // behavioural model of one accepted activation
    task automatic model_run(input int s);
        logic [31:0] p, w0, sa, da, dv;
        logic [15:0] c;
        bit go;
        p  = 32'(s) * 256;
        go = 1;
        while (go) begin
            w0 = sh[p[11:2]]; sa = sh[p[11:2] + 1]; da = sh[p[11:2] + 2];
            pushx(0, p, 0, "R2"); pushx(0, p + 4, 0, "R2"); pushx(0, p + 8, 0, "R2");
            pushx(0, sa, 0, "R2");
            dv = sh[sa[11:2]];
            pushx(1, da, dv, "R2");
            sh[da[11:2]] = dv;
            c = w0[15:0] - 16'd1;
            pushx(1, p, {w0[31:16], c}, "R9");
            sh[p[11:2]] = {w0[31:16], c};
            if (w0[31]) begin
                if (!w0[29] || c == 0) p = p + 16;   // R4 R5
                else go = 0;
            end else begin
                go = 0;
                if (c == 0) begin men[s] = 1'b0; pushx(3, 0, 32'(s), "R8"); end
                else if (w0[30]) pushx(3, 0, 32'(s), "R7");
                else pushx(2, 0, 32'(s), "R6");
            end
        end
    endtask

    task automatic set_desc(input int s, input int k, input logic [7:0] mode,
                            input logic [15:0] cnt, input logic [31:0] sa,
                            input logic [31:0] da);
        int b;
        b = (s * 256 + k * 16) / 4;
        mem[b] = {mode, 8'h5A, cnt}; sh[b] = {mode, 8'h5A, cnt};
        mem[b+1] = sa; sh[b+1] = sa;
        mem[b+2] = da; sh[b+2] = da;
        mem[b+3] = 0;  sh[b+3] = 0;
    endtask

    // per-clock comparison and memory service
    logic [7:0]  lfsr = 8'h5D;
    bit          stall_prev = 0;
    logic [31:0] addr_prev = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev) check("R3", "held request address", mem_addr, addr_prev);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_ready = lfsr[0] | lfsr[2];
            stall_prev = mem_req && !mem_ready;
            addr_prev  = mem_addr;
            if (mem_req && mem_ready) begin
                if (qk.size() == 0) check("R1", "unexpected beat", mem_addr, 32'hFFFF_FFFF);
                else begin
                    int k; logic [31:0] a, d; string t;
                    k = qk.pop_front(); a = qa.pop_front(); d = qd.pop_front(); t = qt.pop_front();
                    check(t, "beat kind", {31'd0, mem_we}, (k == 1) ? 32'd1 : ((k == 0) ? 32'd0 : 32'd9));
                    check(t, "beat address", mem_addr, a);
                    if (k == 1) check(t, "write data", mem_wdata, d);
                end
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
            end
            if (src_clr || cpu_irq) begin
                if (qk.size() == 0) check("R12", "unexpected event", {30'd0, src_clr, cpu_irq}, 0);
                else begin
                    int k; logic [31:0] d; string t;
                    k = qk.pop_front(); void'(qa.pop_front()); d = qd.pop_front(); t = qt.pop_front();
                    check(t, "event kind", {30'd0, src_clr, cpu_irq}, (k == 2) ? 32'd2 : ((k == 3) ? 32'd1 : 32'd0));
                    check(t, "event source", src_clr ? 32'(src_clr_id) : 32'(cpu_irq_id), d);
                end
            end
        end
    end

    task automatic activate(input int s);
        @(negedge clk);
        act_req = 1'b1; act_src = SW'(s);
        if (men[s]) model_run(s);
        @(negedge clk);
        act_req = 1'b0;
    endtask

    task automatic settle();
        while (qk.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic write_en(input logic [NSRC-1:0] v);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
        men = v;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 32'hC000_0000 + 32'(i) * 32'h0101_0007;
            sh[i]  = mem[i];
        end
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "reset en_q", 32'(en_q), 0);
        check("R12", "reset mem_req", {31'd0, mem_req}, 0);
        check("R12", "reset events", {30'd0, src_clr, cpu_irq}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 disabled source ignored
        set_desc(0, 0, 8'h00, 16'd3, 32'h800, 32'h900);
        activate(0);
        repeat (20) @(negedge clk);
        check("R1", "no activation while disabled", 32'(en_q), 0);

        write_en('1);
        check("R10", "software enable write", 32'(en_q), 32'hFF);

        // R6 plain end with flag clear
        activate(0); settle();
        // R8 count exhausted
        set_desc(1, 0, 8'h00, 16'd1, 32'h804, 32'h904);
        activate(1); settle();
        check("R8", "enable cleared at zero count", 32'(en_q), 32'hFD);
        activate(1); repeat (20) @(negedge clk);   // R1 now ignored
        // R4 always chain, then R7 forward
        set_desc(2, 0, 8'h80, 16'd7, 32'h808, 32'h908);
        set_desc(2, 1, 8'h40, 16'd5, 32'h80C, 32'h90C);
        activate(2); settle();
        // R5 conditional chain not taken
        set_desc(3, 0, 8'hA0, 16'd4, 32'h810, 32'h910);
        activate(3); settle();
        check("R5", "no enable change without chain", 32'(en_q), 32'hFD);
        // R5 conditional chain taken
        set_desc(4, 0, 8'hA0, 16'd1, 32'h814, 32'h914);
        set_desc(4, 1, 8'h00, 16'd9, 32'h818, 32'h918);
        activate(4); settle();
        // R9 reserved bits
        set_desc(5, 0, 8'h1F, 16'd2, 32'h81C, 32'h91C);
        activate(5); settle();
        set_desc(5, 0, 8'h5F, 16'd6, 32'h820, 32'h920);
        activate(5); settle();
        // R11 zero count wraps
        set_desc(6, 0, 8'h00, 16'd0, 32'h824, 32'h924);
        activate(6); settle();
        check("R11", "wrapped count keeps enable", 32'(en_q), 32'hFD);
        // R1 request during busy chain
        set_desc(7, 0, 8'h80, 16'd2, 32'h828, 32'h928);
        set_desc(7, 1, 8'h80, 16'd2, 32'h82C, 32'h92C);
        set_desc(7, 2, 8'h00, 16'd2, 32'h830, 32'h930);
        activate(7);
        repeat (4) @(negedge clk);
        act_req = 1'b1; act_src = 3'd0;
        @(negedge clk);
        act_req = 1'b0;
        settle();
        // R10 software write in the clearing cycle
        set_desc(0, 0, 8'h00, 16'd1, 32'h834, 32'h934);
        activate(0);
        do @(negedge clk); while (!cpu_irq);
        en_wr = 1'b1; en_wdata = '1;
        @(negedge clk);
        en_wr = 1'b0;
        men = '1; men[0] = 1'b0;
        settle();
        check("R10", "clear wins over write", 32'(en_q), 32'(men));
        check("R2", "all expected beats seen", 32'(qk.size()), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R12 watchdog actual=%h expected=%h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule